// File: doc/BRIEF.md
# I2C Bus Status Tracker

This block watches the two wires of an I2C bus, clock and data, along with strobes from the local I2C shift engine. From them it keeps a six-bit status word. Two-flop synchronizers bring the lines into the clock domain. An edge detector then finds START and STOP conditions.

The word has two kinds of bit. Level bits follow bus state and software cannot change them:

- transfer direction
- last acknowledge value
- the local unit is busy
- another master holds the bus

Event bits record things that have happened:

- a STOP was seen while the unit acted as slave
- arbitration was lost

Event bits stay set until software reads the word. The read port has a strobe input and a registered 32-bit data output.

The engine tells the tracker four things:

- whether it takes part in the current transfer (claim)
- whether it acts as slave
- the R/W bit of each address byte
- the acknowledge value after each byte

On every sampled bit it also says whether it was releasing data high. The tracker uses that to detect a lost arbitration.

Top module: `i2c_stat_tracker`

## Requirements
- R1: After reset every status bit is 0 and `rd_data` is 0. Reserved bits 31..6 always read 0.
- R2: A START is data falling while clock is high. A STOP is data rising while clock is high. Both are judged on the synchronized lines. A data change while clock is low is neither.
- R3: Bit 3 (foreign busy) is 1 from a START to the next STOP while the local unit has not claimed the transfer. It is 0 while the bus is idle.
- R4: Bit 2 (unit busy) is set in the first cycle in which `eng_claim` is high while the bus is active after a START. It is cleared by the STOP. While bit 2 is 1, bit 3 reads 0.
- R5: Bit 0 (direction) takes `eng_rw` when `eng_addr_stb` pulses: 1 means master-receive or slave-transmit. A STOP clears it.
- R6: Bit 1 (acknowledge) takes `eng_nack` when `eng_ack_stb` pulses: 0 means ACK, 1 means NACK. It holds between strobes.
- R7: Bit 4 (slave STOP) is set when a STOP arrives while bit 2 is 1 and `eng_slave` is 1. A STOP that ends a master transfer leaves it 0.
- R8: Bit 5 (arbitration lost) is set when `eng_bit_smp` pulses with `eng_sda_hi` = 1 while synchronized clock is high and synchronized data is low. With `eng_sda_hi` = 0 the pulse does not set it.
- R9: A read returns the word as it stood in the strobe cycle and then clears bits 5 and 4. Bits 3..0 are not affected by a read.
- R10: When an event sets a flag in the same cycle as a clearing read, the flag is left at 1. The read returns the old value.
- R11: `rd_data` updates in the cycle after `rd_stb` and holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| eng_claim | input | 1 | Local engine takes part in the current transfer |
| eng_slave | input | 1 | Local engine acts as slave |
| eng_addr_stb | input | 1 | Address byte R/W bit is valid |
| eng_rw | input | 1 | R/W bit of the address byte |
| eng_ack_stb | input | 1 | Acknowledge bit has been seen |
| eng_nack | input | 1 | Acknowledge value, 1 = NACK |
| eng_bit_smp | input | 1 | Engine samples an address or data bit |
| eng_sda_hi | input | 1 | Engine was releasing data high for that bit |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 32 | Status word, valid the cycle after the strobe |

## Verification
The bench produces conditions in four ways:

- data toggled with clock low, where nothing may happen
- a START and STOP without a claim, which separates foreign busy from unit busy
- a claimed transfer ended in slave mode and one ended in master mode, which shows whether slave STOP is qualified by mode
- an arbitration sample taken with data low, once with the engine releasing the line and once without

Repeated reads show that event bits clear and level bits do not. A read issued in the same cycle as an arbitration event shows that the set is not lost to the clear.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W = 6;
    localparam int WORD_W = 32;

    // Bit order is the software-visible layout: bit 0 is direction.
    typedef struct packed {
        logic arb_lost;   // bit 5, event
        logic slv_stop;   // bit 4, event
        logic ext_busy;   // bit 3, level
        logic unit_busy;  // bit 2, level
        logic nack;       // bit 1, level
        logic dir;        // bit 0, level
    } stat_t;

    typedef struct packed {
        logic start;
        logic stop;
    } cond_t;

    // Word as returned to software: reserved bits are zero.
    function automatic logic [WORD_W-1:0] to_word(stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[STAT_W-1:0] = s;
        return w;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_s,
    input  logic  sda_s,
    output cond_t cond
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        cond.start = scl_s & scl_q & sda_q & ~sda_s;
        cond.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end

    // R2: a detected condition always follows a data change
    a_r2_cond_on_sda_edge: assert property (@(posedge clk) disable iff (rst)
        (cond.start | cond.stop) |=> $past(sda_s) != $past(sda_q));
endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
    import i2c_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cond_t cond,
    input  logic  scl_s,
    input  logic  sda_s,
    input  logic  eng_claim,
    input  logic  eng_slave,
    input  logic  eng_addr_stb,
    input  logic  eng_rw,
    input  logic  eng_ack_stb,
    input  logic  eng_nack,
    input  logic  eng_bit_smp,
    input  logic  eng_sda_hi,
    input  logic  rd_stb,
    output stat_t stat
);
    logic active_q, unit_q, dir_q, nack_q, slv_q, arb_q;
    logic arb_set, slv_set;

    assign arb_set = eng_bit_smp & eng_sda_hi & scl_s & ~sda_s;
    assign slv_set = cond.stop & unit_q & eng_slave;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            unit_q   <= 1'b0;
            dir_q    <= 1'b0;
            nack_q   <= 1'b0;
            slv_q    <= 1'b0;
            arb_q    <= 1'b0;
        end else begin
            if (cond.stop)       active_q <= 1'b0;
            else if (cond.start) active_q <= 1'b1;

            if (cond.stop)                  unit_q <= 1'b0;
            else if (eng_claim && active_q) unit_q <= 1'b1;

            if (cond.stop)         dir_q <= 1'b0;
            else if (eng_addr_stb) dir_q <= eng_rw;

            if (eng_ack_stb) nack_q <= eng_nack;

            // set wins over the read clear
            slv_q <= slv_set | (slv_q & ~rd_stb);
            arb_q <= arb_set | (arb_q & ~rd_stb);
        end
    end

    always_comb begin
        stat.arb_lost  = arb_q;
        stat.slv_stop  = slv_q;
        stat.ext_busy  = active_q & ~unit_q;
        stat.unit_busy = unit_q;
        stat.nack      = nack_q;
        stat.dir       = dir_q;
    end

    a_r3_idle_after_stop: assert property (@(posedge clk) disable iff (rst)
        cond.stop |=> !stat.ext_busy && !stat.unit_busy);
    a_r4_unit_within_bus: assert property (@(posedge clk) disable iff (rst)
        stat.unit_busy |-> active_q);
    a_r5_dir_clear_on_stop: assert property (@(posedge clk) disable iff (rst)
        cond.stop |=> !stat.dir);
    a_r9_read_clears_arb: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !arb_set |=> !stat.arb_lost);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        arb_set |=> stat.arb_lost);
endmodule

// File: rtl/i2c_rd_port.sv
module i2c_rd_port
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  stat_t             stat,
    output logic [WORD_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_stb) rd_data <= to_word(stat);
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[WORD_W-1:STAT_W] == '0);
    a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/i2c_stat_tracker.sv
module i2c_stat_tracker
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        eng_claim,
    input  logic        eng_slave,
    input  logic        eng_addr_stb,
    input  logic        eng_rw,
    input  logic        eng_ack_stb,
    input  logic        eng_nack,
    input  logic        eng_bit_smp,
    input  logic        eng_sda_hi,
    input  logic        rd_stb,
    output logic [31:0] rd_data
);
    logic [1:0] lines_s;
    cond_t      cond;
    stat_t      stat;

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );

    i2c_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .cond  (cond)
    );

    i2c_stat_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .cond         (cond),
        .scl_s        (lines_s[1]),
        .sda_s        (lines_s[0]),
        .eng_claim    (eng_claim),
        .eng_slave    (eng_slave),
        .eng_addr_stb (eng_addr_stb),
        .eng_rw       (eng_rw),
        .eng_ack_stb  (eng_ack_stb),
        .eng_nack     (eng_nack),
        .eng_bit_smp  (eng_bit_smp),
        .eng_sda_hi   (eng_sda_hi),
        .rd_stb       (rd_stb),
        .stat         (stat)
    );

    i2c_rd_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .stat    (stat),
        .rd_data (rd_data)
    );
endmodule

// File: tb/tb_i2c_stat_tracker.sv
`timescale 1ns/1ps
module tb_i2c_stat_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic eng_claim = 0, eng_slave = 0, eng_addr_stb = 0, eng_rw = 0;
    logic eng_ack_stb = 0, eng_nack = 0, eng_bit_smp = 0, eng_sda_hi = 0;
    logic rd_stb = 0;
    logic [31:0] rd_data;

    int tests = 0, fails = 0;
    bit done = 0;
    logic rd_seen = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    i2c_stat_tracker dut (.*);

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic c, input logic d);
        scl_in = c; sda_in = d;
        idle(5);
    endtask

    // driver: push expected word, issue strobe
    task automatic rd(input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_stb = 1'b1;
        idle(1);
        rd_stb = 1'b0;
        idle(2);
    endtask

    task automatic pulse_bit(input logic hi, input logic with_read, input logic [31:0] exp, input string tag);
        eng_bit_smp = 1'b1; eng_sda_hi = hi;
        if (with_read) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
            rd_stb = 1'b1;
        end
        idle(1);
        eng_bit_smp = 1'b0; eng_sda_hi = 1'b0; rd_stb = 1'b0;
        idle(2);
    endtask

    always @(posedge clk) rd_seen <= rd_stb;

    // monitor: compare each read result with the queued expectation
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R11: unexpected read result %h expected none", rd_data);
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        check(rd_data, 32'h0, "R1 reset rd_data");
        rd(32'h0, "R1 reset status");

        // R2: data toggles with clock low are no condition
        lines(1'b0, 1'b1);
        lines(1'b0, 1'b0);
        lines(1'b0, 1'b1);
        rd(32'h0, "R2 no condition with clock low");

        // R3: foreign transfer
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        rd(32'h08, "R2 R3 start sets foreign busy");
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        rd(32'h0, "R2 R3 stop clears foreign busy");

        // R4..R7: claimed transfer ending as slave
        lines(1'b1, 1'b0);
        eng_claim = 1'b1;
        idle(2);
        rd(32'h04, "R4 unit busy hides foreign busy");
        eng_rw = 1'b1; eng_addr_stb = 1'b1; idle(1); eng_addr_stb = 1'b0;
        rd(32'h05, "R5 direction from rw");
        eng_nack = 1'b1; eng_ack_stb = 1'b1; idle(1); eng_ack_stb = 1'b0; eng_nack = 1'b0;
        rd(32'h07, "R6 nack captured");
        rd(32'h07, "R9 level bits survive read");
        eng_ack_stb = 1'b1; idle(1); eng_ack_stb = 1'b0;
        rd(32'h05, "R6 ack captured");
        eng_slave = 1'b1;
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        eng_claim = 1'b0; eng_slave = 1'b0;
        rd(32'h10, "R7 R5 slave stop set, direction cleared");
        rd(32'h00, "R9 slave stop cleared by read");

        // R7: master transfer does not set slave stop
        lines(1'b1, 1'b0);
        eng_claim = 1'b1;
        idle(2);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        eng_claim = 1'b0;
        rd(32'h00, "R7 master stop leaves flag clear");

        // R8: arbitration, data held low by another master
        lines(1'b1, 1'b0);
        pulse_bit(1'b0, 1'b0, 32'h0, "");
        rd(32'h08, "R8 no loss when not releasing");
        pulse_bit(1'b1, 1'b0, 32'h0, "");
        rd(32'h28, "R8 arbitration lost");
        rd(32'h08, "R9 arbitration flag cleared by read");

        // R10: event and read in one cycle
        pulse_bit(1'b1, 1'b1, 32'h08, "R10 read returns old value");
        rd(32'h28, "R10 set survives clearing read");
        idle(4);
        check(rd_data, 32'h28, "R11 rd_data holds between strobes");

        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        rd(32'h00, "R3 bus idle after stop");

        idle(4);
        check(32'(exp_q.size()), 32'h0, "R11 every read answered");
        finish_run();
    end
endmodule